// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies bytes out of a one-time-programmable fuse array into a small bank of result words that software can read. Software first sets two timing fields in a configuration register. It then writes a control word that gives a starting byte address, a bank bit, and a transfer size encoded as count minus one. The sequencer steps through the requested bytes one at a time. For each byte it presents the fuse address, waits out a setup interval, and pulses a read strobe. It samples the byte from the fuse array as the strobe ends, and it posts a done flag once the last byte is in place.

The fuse macro is treated as a byte-wide synchronous memory holding two banks of 512 bytes. The 10-bit fuse address is the bank bit followed by a 9-bit byte address. One transaction moves 1 to 32 bytes. The bytes are packed little-endian into eight 32-bit result words. Every result word is zeroed when a transaction starts.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: The registers sit at fixed offsets from the base 0xD0: control +0x00, configuration +0x04, status +0x08, and result word n at +0x0C+4n for n = 0..7. The configuration register keeps the strobe width in bits 19:16 and the setup interval in bits 23:20, and reads back those bits with all other bits zero. After reset every register reads zero.
- R2: Writing the control register with bit 0 set while no transaction is running starts a transaction. The same write latches the size field (bits 20:16, holding count-1), the start address (bits 29:21) and the bank bit (bit 30). Control bit 0 reads 1 while the transaction runs and returns to 0 on its own when it ends. The latched fields read back in their bit positions.
- R3: For each byte, the fuse address is held with the strobe low for setup+1 cycles. The strobe is then high for width+1 cycles. The byte is captured at the clock edge on which the strobe drops, and the next byte's setup phase follows at once.
- R4: The address of byte k is {bank, (start + k) mod 512}. The address wraps within the selected bank.
- R5: Byte k lands in result word k/4 at byte lane k%4, where lane 0 is bits 7:0. A transaction of 1 to 3 bytes therefore fills only the low lanes of word 0.
- R6: A start clears every result word. Lanes beyond the requested size read zero after the transaction.
- R7: Status bit 0 reads 1 from the cycle after the last byte is captured. A new start clears it.
- R8: A control write made while a transaction runs is ignored. The latched fields, the address sequence and the strobe timing are unchanged.
- R9: The timing fields are sampled at start. A configuration write during a transaction changes the readback at once but applies only to the next transaction.
- R10: Writes to the status offset and to the result-word offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| fuse_addr | output | 10 | Fuse array address {bank, byte address} |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_rdata | input | 8 | Byte from the fuse array, valid one cycle after the address |

## Verification
A wrong phase counter or byte index in the sequencer shows on fuse_strobe or fuse_addr in the very cycle it diverges, so the bench compares both pins against its timeline model on every clock. A byte captured into the wrong lane, or a lane left uncleared at start, is invisible until the result words are read, so every transaction ends with a full register readback. A finish flag raised too early or too late is caught through the status and control readback taken mid-run and after completion. A control or configuration write made during a run that leaks into the active transaction shifts the strobe pattern within one byte period.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  // register offsets relative to the block base
  localparam int OFS_CTRL = 0;
  localparam int OFS_CFG  = 4;
  localparam int OFS_STAT = 8;
  localparam int OFS_DATA = 12;

  // control word layout
  localparam int CTL_GO      = 0;
  localparam int CTL_LEN_LSB = 16;
  localparam int CTL_ADR_LSB = 21;

  // configuration word layout
  localparam int CFG_STB_LSB = 16;
  localparam int CFG_ADJ_LSB = 20;

  // status word layout
  localparam int STAT_DONE = 0;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADJ  = 2'd1,
    SQ_STB  = 2'd2
  } sq_state_e;

endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int BUS_AW   = 8,
  parameter int BASE_OFS = 'hD0,
  parameter int NWORDS   = 8,
  parameter int LEN_W    = 5,
  parameter int ADDR_W   = 9,
  parameter int TCNT_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic                   busy,
  input  logic                   done,
  input  logic [NWORDS*32-1:0]   words,
  output logic                   start,
  output logic [TCNT_W-1:0]      cfg_adj,
  output logic [TCNT_W-1:0]      cfg_stb,
  output logic [LEN_W-1:0]       ctl_len,
  output logic [ADDR_W-1:0]      ctl_addr,
  output logic                   ctl_bank
);

  localparam int WIDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int CTL_BANK = CTL_ADR_LSB + ADDR_W;

  logic [BUS_AW-1:0] off;
  logic [BUS_AW-1:0] doff;
  logic              hit_ctrl, hit_cfg, hit_stat, hit_data;
  logic [WIDX_W-1:0] widx;

  assign off      = bus_addr - BUS_AW'(BASE_OFS);
  assign doff     = off - BUS_AW'(OFS_DATA);
  assign hit_ctrl = (off == BUS_AW'(OFS_CTRL));
  assign hit_cfg  = (off == BUS_AW'(OFS_CFG));
  assign hit_stat = (off == BUS_AW'(OFS_STAT));
  assign hit_data = (off >= BUS_AW'(OFS_DATA)) && (doff < BUS_AW'(4 * NWORDS)) &&
                    (off[1:0] == 2'b00);
  assign widx     = doff[WIDX_W+1:2];

  // a go request is honoured only between transactions
  assign start = bus_wr && hit_ctrl && bus_wdata[CTL_GO] && !busy;

  logic                cfg_we;
  logic [TCNT_W-1:0]   adj_q, adj_d, stb_q, stb_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [ADDR_W-1:0]   adr_q, adr_d;
  logic                bank_q, bank_d;

  assign cfg_we = bus_wr && hit_cfg;

  always_comb begin
    adj_d  = adj_q;
    stb_d  = stb_q;
    len_d  = len_q;
    adr_d  = adr_q;
    bank_d = bank_q;
    if (cfg_we) begin
      adj_d = bus_wdata[CFG_ADJ_LSB +: TCNT_W];
      stb_d = bus_wdata[CFG_STB_LSB +: TCNT_W];
    end
    if (start) begin
      len_d  = bus_wdata[CTL_LEN_LSB +: LEN_W];
      adr_d  = bus_wdata[CTL_ADR_LSB +: ADDR_W];
      bank_d = bus_wdata[CTL_BANK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q  <= '0;
      stb_q  <= '0;
      len_q  <= '0;
      adr_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      adj_q  <= adj_d;
      stb_q  <= stb_d;
      len_q  <= len_d;
      adr_q  <= adr_d;
      bank_q <= bank_d;
    end
  end

  assign cfg_adj  = adj_q;
  assign cfg_stb  = stb_q;
  assign ctl_len  = len_q;
  assign ctl_addr = adr_q;
  assign ctl_bank = bank_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CTL_GO]                  = busy;
      bus_rdata[CTL_LEN_LSB +: LEN_W]    = len_q;
      bus_rdata[CTL_ADR_LSB +: ADDR_W]   = adr_q;
      bus_rdata[CTL_BANK]                = bank_q;
    end else if (hit_cfg) begin
      bus_rdata[CFG_ADJ_LSB +: TCNT_W]   = adj_q;
      bus_rdata[CFG_STB_LSB +: TCNT_W]   = stb_q;
    end else if (hit_stat) begin
      bus_rdata[STAT_DONE]               = done;
    end else if (hit_data) begin
      bus_rdata = words[{widx, 5'b00000} +: 32];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int ADDR_W = 9,
  parameter int TCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TCNT_W-1:0] cfg_adj,
  input  logic [TCNT_W-1:0] cfg_stb,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              strobe,
  output logic [ADDR_W-1:0] word_addr,
  output logic              cap_en,
  output logic [LEN_W-1:0]  cap_idx
);

  sq_state_e         st_q, st_d;
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic [TCNT_W-1:0] adj_q, adj_d, stb_q, stb_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic              done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    adj_d  = adj_q;
    stb_d  = stb_q;
    idx_d  = idx_q;
    done_d = done_q;
    cap_en = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_ADJ;
          cnt_d  = '0;
          idx_d  = '0;
          adj_d  = cfg_adj;
          stb_d  = cfg_stb;
          done_d = 1'b0;
        end
      end
      SQ_ADJ: begin
        if (cnt_q == adj_q) begin
          st_d  = SQ_STB;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_STB: begin
        if (cnt_q == stb_q) begin
          cap_en = 1'b1;
          cnt_d  = '0;
          if (idx_q == len) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end else begin
            st_d  = SQ_ADJ;
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      adj_q  <= '0;
      stb_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      adj_q  <= adj_d;
      stb_q  <= stb_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign strobe    = (st_q == SQ_STB);
  assign done      = done_q;
  assign cap_idx   = idx_q;
  assign word_addr = base_addr + ADDR_W'(idx_q);

endmodule

// File: rtl/fuse_rd_pack.sv
module fuse_rd_pack #(
  parameter int NWORDS = 8,
  parameter int LEN_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 cap_en,
  input  logic [LEN_W-1:0]     cap_idx,
  input  logic [7:0]           cap_byte,
  output logic [NWORDS*32-1:0] words
);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar l = 0; l < 4; l++) begin : g_lane
      localparam int BIDX = w * 4 + l;
      logic [7:0] lane_q, lane_d;
      logic       hit;

      assign hit = cap_en && (cap_idx == LEN_W'(BIDX));

      always_comb begin
        lane_d = lane_q;
        if (clear)    lane_d = '0;
        else if (hit) lane_d = cap_byte;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
      end

      assign words[BIDX*8 +: 8] = lane_q;
    end
  end

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int BUS_AW   = 8,
  parameter int BASE_OFS = 'hD0,
  parameter int NWORDS   = 8,
  parameter int ADDR_W   = 9,
  parameter int TCNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ADDR_W:0]   fuse_addr,
  output logic              fuse_strobe,
  input  logic [7:0]        fuse_rdata
);

  localparam int LEN_W = $clog2(NWORDS * 4);

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                 start, seq_busy, seq_done, cap_en;
  logic [TCNT_W-1:0]    cfg_adj, cfg_stb;
  logic [LEN_W-1:0]     ctl_len, cap_idx;
  logic [ADDR_W-1:0]    ctl_addr, word_addr;
  logic                 ctl_bank;
  logic [NWORDS*32-1:0] words;

  fuse_rd_regs #(
    .BUS_AW(BUS_AW), .BASE_OFS(BASE_OFS), .NWORDS(NWORDS),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .TCNT_W(TCNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(seq_busy), .done(seq_done), .words(words),
    .start(start), .cfg_adj(cfg_adj), .cfg_stb(cfg_stb),
    .ctl_len(ctl_len), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank)
  );

  fuse_rd_seq #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .TCNT_W(TCNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .cfg_adj(cfg_adj), .cfg_stb(cfg_stb),
    .len(ctl_len), .base_addr(ctl_addr),
    .busy(seq_busy), .done(seq_done), .strobe(fuse_strobe),
    .word_addr(word_addr), .cap_en(cap_en), .cap_idx(cap_idx)
  );

  fuse_rd_pack #(
    .NWORDS(NWORDS), .LEN_W(LEN_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_sync_n), .clear(start),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_byte(fuse_rdata),
    .words(words)
  );

  assign fuse_addr = {ctl_bank, word_addr};

endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk #(
  parameter int BUS_AW   = 8,
  parameter int BASE_OFS = 'hD0,
  parameter int ADDR_W   = 9,
  parameter int LEN_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_go,
  input logic              busy,
  input logic              done,
  input logic              fuse_strobe,
  input logic [ADDR_W:0]   fuse_addr,
  input logic [LEN_W-1:0]  ctl_len,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic              ctl_bank
);

  // R2: an accepted go write makes the sequencer busy on the next cycle
  a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == BUS_AW'(BASE_OFS) && bus_go && !busy) |=> busy);

  // R8: latched transfer fields do not move while a transfer runs
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ctl_len) && $stable(ctl_addr) && $stable(ctl_bank)));

  // R7: the finish of a transfer posts done, a new start clears it
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

  // R3: the address never changes under an active strobe
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> $stable(fuse_addr));

  // R3: the strobe only pulses inside a transfer
  a_r3_strobe_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> busy);

endmodule

bind fuse_rd_ctrl fuse_rd_chk #(
  .BUS_AW(BUS_AW), .BASE_OFS(BASE_OFS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_go(bus_wdata[0]),
  .busy(seq_busy), .done(seq_done),
  .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr),
  .ctl_len(ctl_len), .ctl_addr(ctl_addr), .ctl_bank(ctl_bank)
);

// File: tb/fuse_rd_ctrl_test.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_test;

  localparam logic [7:0] A_CTRL = 8'hD0;
  localparam logic [7:0] A_CFG  = 8'hD4;
  localparam logic [7:0] A_STAT = 8'hD8;
  localparam logic [7:0] A_DATA = 8'hDC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [9:0]  fuse_addr;
  logic        fuse_strobe;
  logic [7:0]  fuse_q;

  always #2.5 clk = ~clk;

  fuse_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .fuse_rdata(fuse_q)
  );

  // fuse array: two banks of 512 bytes, one cycle read latency
  logic [7:0] fuse_mem [0:1023];
  initial begin
    for (int i = 0; i < 1024; i++) fuse_mem[i] = 8'((i * 29 + 7) ^ (i >> 2));
  end
  always @(posedge clk) fuse_q <= fuse_mem[fuse_addr];

  int n_vec = 0;
  int n_bad = 0;

  // behavioural timeline model
  bit         m_act, m_done;
  int         m_s, m_adj, m_stb, m_cfg_adj, m_cfg_stb, m_len, m_addr, m_bank;
  logic [7:0] m_buf [0:31];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_s = 0; m_adj = 0; m_stb = 0;
      m_cfg_adj = 0; m_cfg_stb = 0; m_len = 0; m_addr = 0; m_bank = 0;
      for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;
    end else begin
      bit was;
      int per;
      was = m_act;
      if (m_act) begin
        per = m_adj + m_stb + 2;
        m_s = m_s + 1;
        if (m_s % per == 0) begin
          int k;
          k = m_s / per - 1;
          m_buf[k] = fuse_mem[m_bank * 512 + ((m_addr + k) % 512)];
        end
        if (m_s == (m_len + 1) * per) begin
          m_act = 0;
          m_done = 1;
        end
      end
      if (bus_wr && bus_addr == A_CFG) begin
        m_cfg_adj = int'(bus_wdata[23:20]);
        m_cfg_stb = int'(bus_wdata[19:16]);
      end
      if (bus_wr && bus_addr == A_CTRL && bus_wdata[0] && !was) begin
        m_act = 1; m_done = 0; m_s = 0;
        m_adj = m_cfg_adj; m_stb = m_cfg_stb;
        m_len = int'(bus_wdata[20:16]);
        m_addr = int'(bus_wdata[29:21]);
        m_bank = int'(bus_wdata[30]);
        for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the fuse pins
  always @(negedge clk) begin
    if (rst_n) begin
      int per;
      bit exp_stb;
      per = m_adj + m_stb + 2;
      exp_stb = m_act && ((m_s % per) >= m_adj + 1);
      check("R3 strobe timing", {31'b0, fuse_strobe}, {31'b0, exp_stb});
      if (m_act)
        check("R4 fuse address", {22'b0, fuse_addr},
              {22'b0, 1'(m_bank), 9'((m_addr + m_s / per) % 512)});
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == A_CTRL)
      r = {1'b0, 1'(m_bank), 9'(m_addr), 5'(m_len), 15'b0, m_act};
    else if (a == A_CFG)
      r = {8'b0, 4'(m_cfg_adj), 4'(m_cfg_stb), 16'b0};
    else if (a == A_STAT)
      r = {31'b0, m_done};
    else if (a >= A_DATA && a <= A_DATA + 8'd28 && a[1:0] == 2'b00) begin
      int n;
      n = int'(a - A_DATA) / 4;
      r = {m_buf[4*n+3], m_buf[4*n+2], m_buf[4*n+1], m_buf[4*n]};
    end
    return r;
  endfunction

  task automatic rd_chk(logic [7:0] a, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_rd(a));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(int lenm1, int addr, int bank);
    return {1'b0, 1'(bank), 9'(addr), 5'(lenm1), 15'b0, 1'b1};
  endfunction

  function automatic logic [31:0] mk_cfg(int adj, int stb);
    return {8'b0, 4'(adj), 4'(stb), 16'b0};
  endfunction

  task automatic wait_idle();
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic all_regs(string tag);
    rd_chk(A_CTRL, tag);
    rd_chk(A_CFG, tag);
    rd_chk(A_STAT, tag);
    for (int n = 0; n < 8; n++) rd_chk(A_DATA + 8'(4 * n), tag);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R7 watchdog: got busy expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    all_regs("R1 reset values");

    // four bytes with modest timing
    wr(A_CFG, mk_cfg(2, 3));
    rd_chk(A_CFG, "R1 config readback");
    wr(A_CTRL, mk_ctrl(3, 'h10, 0));
    rd_chk(A_CTRL, "R2 busy and fields");
    rd_chk(A_STAT, "R7 done low while running");
    wait_idle();
    rd_chk(A_CTRL, "R2 go self-clears");
    rd_chk(A_STAT, "R7 done after last byte");
    all_regs("R5 four byte packing");

    // full 32 bytes, fastest timing, wrapping in bank 1
    wr(A_CFG, mk_cfg(0, 0));
    wr(A_CTRL, mk_ctrl(31, 'h1F0, 1));
    wait_idle();
    all_regs("R4 R5 full transfer with wrap");

    // short read after a full one: high lanes must be cleared
    wr(A_CTRL, mk_ctrl(2, 'h05, 0));
    rd_chk(A_DATA + 8'd28, "R6 words cleared at start");
    wait_idle();
    all_regs("R6 three byte read");

    wr(A_CTRL, mk_ctrl(0, 'h1FF, 1));
    wait_idle();
    all_regs("R6 single byte read");

    // control and config writes during a transfer
    wr(A_CFG, mk_cfg(1, 1));
    wr(A_CTRL, mk_ctrl(15, 'h40, 0));
    repeat (5) @(negedge clk);
    wr(A_CTRL, mk_ctrl(0, 'h000, 1));
    rd_chk(A_CTRL, "R8 control write ignored while busy");
    wr(A_CFG, mk_cfg(7, 9));
    rd_chk(A_CFG, "R9 config readback updates at once");
    wr(A_DATA, 32'hFFFF_FFFF);
    wr(A_STAT, 32'h0000_0001);
    rd_chk(A_STAT, "R10 status write ignored while busy");
    wait_idle();
    all_regs("R8 R9 transfer unaffected");

    // next transfer picks up the new timing
    wr(A_CTRL, mk_ctrl(1, 'h80, 1));
    wait_idle();
    all_regs("R9 new timing applied");

    // writes to read-only offsets
    wr(A_DATA, 32'hFFFF_FFFF);
    wr(A_DATA + 8'd4, 32'h1234_5678);
    wr(A_STAT, 32'h0000_0000);
    all_regs("R10 read-only offsets");

    // slowest timing
    wr(A_CFG, mk_cfg(15, 15));
    wr(A_CTRL, mk_ctrl(4, 'h1FE, 0));
    wait_idle();
    all_regs("R3 R4 widest intervals");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule